// File: doc/BRIEF.md
# Fan Tachometer Speed Monitor

This block watches a set of fan tachometer inputs and reports, for every channel, how many prescaled ticks separate two consecutive rising edges of that fan's pulse train. Each input is brought into the clock domain through a two-flop synchroniser and then reduced to a one-cycle rising-edge strobe. A shared prescaler produces the measurement tick, one every 4^n source cycles, where n is a 4-bit divider setting.

Each channel carries its own minimum-speed setting (in revolutions per minute) and its own pulses-per-revolution setting. Together with the divider these define a sample window. On every tick the channel adds a step of rpm * ppr * 4^n to an accumulator. When that accumulator passes the number of source cycles in one minute, a fan turning at the minimum speed would already have produced its next pulse. The channel then stops waiting, saturates its result to all ones and raises a stall flag. A small write-only register port sets the divider, the channel enables and the per-channel settings. Converting counts into RPM is left to software.

Each channel runs a four-state machine. CH_OFF is the disabled state. CH_ARM waits for the first edge. CH_RUN measures the interval since the last edge. CH_STALL holds a timed-out result. The transitions are:
- "enable": CH_OFF to CH_ARM, when the channel enable is high.
- "first edge": CH_ARM to CH_RUN.
- "measure": CH_RUN to CH_RUN on an edge, which latches the count.
- "timeout": CH_ARM or CH_RUN to CH_STALL, when the window expires on a tick.
- "restart": CH_STALL to CH_RUN on an edge.
- "disable": any state to CH_OFF, when the enable is low.

Top module: `fan_tach_monitor`

## Requirements
- R1: After reset every channel reports result 0, valid 0 and stall 0, all channels are disabled, and the settings hold their defaults: divider 5, pulses-per-revolution 2, minimum speed 1000.
- R2: An input is detected only on its low-to-high transition after synchronisation. A level held high produces a single edge however long it lasts.
- R3: The tick occurs once every 4^n source cycles, where n is the divider (0..15). A write to the divider restarts the tick phase.
- R4: On each edge in CH_RUN, the number of ticks seen strictly between the previous edge and this one is latched into the result, and valid is set. The first edge after enabling only arms the channel and latches nothing.
- R5: If, on a tick with no edge, the accumulated ticks * rpm * ppr * 4^n exceeds CYCLES_PER_MIN, the channel enters CH_STALL. Its result becomes all ones, stall is set and valid is set. An interval that exactly equals the limit is still a valid measurement.
- R6: From CH_STALL, the next edge restarts measurement. The edge after that latches a normal result and clears stall.
- R7: While a channel's enable bit is low, its counter, result, valid and stall are held at zero.
- R8: A pulses-per-revolution setting of 0 is treated as 1. A minimum speed of 0 disables stall detection, and the count then saturates at all ones.
- R9: The register map uses 6-bit addresses and 16-bit data. Address 0x00 holds the divider in bits [3:0]. Address 0x01 holds the enable mask, with bit i for channel i. Address 0x10+i holds the pulses-per-revolution of channel i in bits [3:0]. Address 0x20+i holds the minimum speed of channel i in bits [15:0]. Writes to any other address change nothing.
- R10: Channels measure independently. Activity on one input never alters another channel's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register write address |
| cfg_wdata | input | 16 | Register write data |
| tach_in | input | NUM_CH | Raw tachometer inputs, one per fan |
| res_count | output | NUM_CH*COUNT_W | Latched tick count per channel, channel i at bits [i*COUNT_W +: COUNT_W] |
| res_valid | output | NUM_CH | Result holds a measurement or a timeout |
| res_stall | output | NUM_CH | Window expired without an edge |

## Verification
A rising input reaches the first synchroniser flop at the next clock edge and the second flop one edge later. The edge strobe then updates the result, valid and stall registers at the third edge, so the bench samples four cycles after it raises a pin, on the falling clock edge. A configuration write changes the enable register at its own edge and clears the outputs one edge later, and the step value follows a settings write one edge later. The bench therefore waits three cycles after a disable and programs every setting before enabling a channel. When the divider is above zero, the tick phase relative to the pulses is not fixed, so the bench accepts either the floor or the ceiling of the interval divided by 4^n. At a divider of 0 the expected count is exact.

// File: rtl/fantach_pkg.sv
package fantach_pkg;

    localparam int DIV_W  = 4;
    localparam int PPR_W  = 4;
    localparam int RPM_W  = 16;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 16;

    localparam logic [ADDR_W-1:0] ADDR_DIV      = 6'h00;
    localparam logic [ADDR_W-1:0] ADDR_EN       = 6'h01;
    localparam logic [ADDR_W-1:0] ADDR_PPR_BASE = 6'h10;
    localparam logic [ADDR_W-1:0] ADDR_RPM_BASE = 6'h20;

    localparam logic [DIV_W-1:0] DIV_RST = 4'd5;
    localparam logic [PPR_W-1:0] PPR_RST = 4'd2;
    localparam logic [RPM_W-1:0] RPM_RST = 16'd1000;

    typedef enum logic [1:0] {
        CH_OFF,
        CH_ARM,
        CH_RUN,
        CH_STALL
    } ch_state_e;

endpackage

// File: rtl/fantach_prescaler.sv
module fantach_prescaler
    import fantach_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    input  logic             restart,
    output logic             tick
);
    localparam int CNT_W = 2 * ((1 << DIV_W) - 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    // 4^div - 1; at div = 15 the shift wraps to zero and the subtraction gives all ones
    always_comb begin
        limit = (CNT_W'(1) << {div, 1'b0}) - CNT_W'(1);
        tick  = (cnt == limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/fantach_cfg.sv
module fantach_cfg
    import fantach_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ACC_W  = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [DATA_W-1:0]             wdata,
    output logic [DIV_W-1:0]              div,
    output logic                          div_wr,
    output logic [NUM_CH-1:0]             en,
    output logic [NUM_CH-1:0][ACC_W-1:0]  step
);
    localparam int PROD_W = RPM_W + PPR_W;

    logic [DIV_W-1:0]  div_q;
    logic [NUM_CH-1:0] en_q;

    assign div    = div_q;
    assign en     = en_q;
    assign div_wr = we && (addr == ADDR_DIV);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= DIV_RST;
            en_q  <= '0;
        end else if (we) begin
            if (addr == ADDR_DIV) begin
                div_q <= wdata[DIV_W-1:0];
            end
            if (addr == ADDR_EN) begin
                en_q <= wdata[NUM_CH-1:0];
            end
        end
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic [PPR_W-1:0]  ppr_q;
        logic [RPM_W-1:0]  rpm_q;
        logic [PPR_W-1:0]  ppr_eff;
        logic [PROD_W-1:0] prod;
        logic              hit_ppr;
        logic              hit_rpm;

        assign hit_ppr = we && (addr == ADDR_PPR_BASE + ADDR_W'(ch));
        assign hit_rpm = we && (addr == ADDR_RPM_BASE + ADDR_W'(ch));

        always_comb begin
            ppr_eff = (ppr_q == '0) ? PPR_W'(1) : ppr_q;
            prod    = PROD_W'(rpm_q) * PROD_W'(ppr_eff);
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ppr_q    <= PPR_RST;
                rpm_q    <= RPM_RST;
                step[ch] <= '0;
            end else begin
                if (hit_ppr) begin
                    ppr_q <= wdata[PPR_W-1:0];
                end
                if (hit_rpm) begin
                    rpm_q <= wdata[RPM_W-1:0];
                end
                step[ch] <= ACC_W'(prod) << {div_q, 1'b0};
            end
        end
    end

endmodule

// File: rtl/fantach_channel.sv
module fantach_channel
    import fantach_pkg::*;
#(
    parameter int               COUNT_W = 16,
    parameter int               ACC_W   = 64,
    parameter logic [ACC_W-1:0] WINDOW  = 64'd7500000000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               tick,
    input  logic               pin,
    input  logic [ACC_W-1:0]   step,
    output logic [COUNT_W-1:0] result,
    output logic               valid,
    output logic               stall
);
    logic               sync1, sync2, sync3;
    logic               rise;
    logic [COUNT_W-1:0] count;
    logic [ACC_W-1:0]   acc;
    logic [ACC_W:0]     acc_sum;
    logic               expire;
    ch_state_e          state, state_nx;

    // input synchroniser and edge detector
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
            sync3 <= 1'b0;
        end else begin
            sync1 <= pin;
            sync2 <= sync1;
            sync3 <= sync2;
        end
    end

    always_comb begin
        rise    = sync2 & ~sync3;
        acc_sum = {1'b0, acc} + {1'b0, step};
        expire  = tick && (acc_sum > {1'b0, WINDOW});
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= CH_OFF;
        end else begin
            state <= state_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        if (!en) begin
            state_nx = CH_OFF;
        end else begin
            unique case (state)
                CH_OFF:   state_nx = CH_ARM;
                CH_ARM:   if (rise) state_nx = CH_RUN;
                          else if (expire) state_nx = CH_STALL;
                CH_RUN:   if (!rise && expire) state_nx = CH_STALL;
                CH_STALL: if (rise) state_nx = CH_RUN;
                default:  state_nx = CH_OFF;
            endcase
        end
    end

    // outputs and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count  <= '0;
            acc    <= '0;
            result <= '0;
            valid  <= 1'b0;
            stall  <= 1'b0;
        end else if (!en) begin
            count  <= '0;
            acc    <= '0;
            result <= '0;
            valid  <= 1'b0;
            stall  <= 1'b0;
        end else begin
            unique case (state)
                CH_OFF: begin
                    count <= '0;
                    acc   <= '0;
                end
                CH_ARM, CH_RUN: begin
                    if (rise) begin
                        if (state == CH_RUN) begin
                            result <= count;
                            valid  <= 1'b1;
                            stall  <= 1'b0;
                        end
                        count <= '0;
                        acc   <= '0;
                    end else if (expire) begin
                        result <= '1;
                        valid  <= 1'b1;
                        stall  <= 1'b1;
                        count  <= '0;
                        acc    <= '0;
                    end else if (tick) begin
                        if (count != '1) begin
                            count <= count + COUNT_W'(1);
                        end
                        acc <= acc_sum[ACC_W-1:0];
                    end
                end
                CH_STALL: begin
                    if (rise) begin
                        count <= '0;
                        acc   <= '0;
                    end
                end
                default: begin
                    count <= '0;
                    acc   <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/fan_tach_monitor.sv
module fan_tach_monitor
    import fantach_pkg::*;
#(
    parameter int          NUM_CH         = 4,
    parameter int          COUNT_W        = 16,
    parameter logic [63:0] CYCLES_PER_MIN = 64'd7500000000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [5:0]                  cfg_addr,
    input  logic [15:0]                 cfg_wdata,
    input  logic [NUM_CH-1:0]           tach_in,
    output logic [NUM_CH*COUNT_W-1:0]   res_count,
    output logic [NUM_CH-1:0]           res_valid,
    output logic [NUM_CH-1:0]           res_stall
);
    localparam int ACC_W = 64;

    logic [DIV_W-1:0]                div;
    logic                            div_wr;
    logic [NUM_CH-1:0]               en_q;
    logic [NUM_CH-1:0][ACC_W-1:0]    step;
    logic                            tick;

    fantach_cfg #(
        .NUM_CH (NUM_CH),
        .ACC_W  (ACC_W)
    ) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .div    (div),
        .div_wr (div_wr),
        .en     (en_q),
        .step   (step)
    );

    fantach_prescaler u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .div     (div),
        .restart (div_wr),
        .tick    (tick)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        fantach_channel #(
            .COUNT_W (COUNT_W),
            .ACC_W   (ACC_W),
            .WINDOW  (CYCLES_PER_MIN)
        ) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (en_q[ch]),
            .tick   (tick),
            .pin    (tach_in[ch]),
            .step   (step[ch]),
            .result (res_count[ch*COUNT_W +: COUNT_W]),
            .valid  (res_valid[ch]),
            .stall  (res_stall[ch])
        );
    end

endmodule

// File: rtl/fan_tach_monitor_chk.sv
module fan_tach_monitor_chk #(
    parameter int NUM_CH  = 4,
    parameter int COUNT_W = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      tick,
    input logic [NUM_CH-1:0]         en,
    input logic [NUM_CH*COUNT_W-1:0] res_count,
    input logic [NUM_CH-1:0]         res_valid,
    input logic [NUM_CH-1:0]         res_stall
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        assert_stall_saturates_R5: assert property (@(posedge clk) disable iff (!rst_n)
            res_stall[i] |-> (res_count[i*COUNT_W +: COUNT_W] == {COUNT_W{1'b1}}));

        assert_stall_is_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
            res_stall[i] |-> res_valid[i]);

        assert_off_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !en[i] |=> (!res_valid[i] && !res_stall[i]));

        assert_valid_drops_only_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(res_valid[i]) |-> !$past(en[i]));

        assert_stall_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(res_stall[i]) |-> $past(tick));
    end
endmodule

bind fan_tach_monitor fan_tach_monitor_chk #(
    .NUM_CH  (NUM_CH),
    .COUNT_W (COUNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .en        (en_q),
    .res_count (res_count),
    .res_valid (res_valid),
    .res_stall (res_stall)
);

// File: tb/tb_fan_tach_monitor.sv
module tb_fan_tach_monitor;
    localparam int          NUM_CH  = 4;
    localparam int          COUNT_W = 16;
    localparam logic [63:0] K       = 64'd60000;

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic                      cfg_we = 1'b0;
    logic [5:0]                cfg_addr = '0;
    logic [15:0]               cfg_wdata = '0;
    logic [NUM_CH-1:0]         tach_in = '0;
    logic [NUM_CH*COUNT_W-1:0] res_count;
    logic [NUM_CH-1:0]         res_valid;
    logic [NUM_CH-1:0]         res_stall;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 0;

    fan_tach_monitor #(
        .NUM_CH(NUM_CH), .COUNT_W(COUNT_W), .CYCLES_PER_MIN(K)
    ) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .tach_in(tach_in), .res_count(res_count),
        .res_valid(res_valid), .res_stall(res_stall)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 150000", cycles);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse(input int ch);
        tach_in[ch] = 1'b1;
        idle(2);
        tach_in[ch] = 1'b0;
    endtask

    // three pulses of period p; returns 4 cycles after the third rise
    task automatic burst3(input int ch, input int p);
        for (int k = 0; k < 2; k++) begin
            pulse(ch);
            idle(p - 2);
        end
        pulse(ch);
        idle(2);
    endtask

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [COUNT_W-1:0] cnt_of(input int ch);
        return res_count[ch*COUNT_W +: COUNT_W];
    endfunction

    // ticks strictly between two edges p cycles apart, tick every m cycles
    function automatic bit in_range(input longint r, input longint p, input longint m);
        longint l = p - 1;
        return (r >= l / m) && (r <= (l + m - 1) / m);
    endfunction

    // divider 0: count or stall expected from the window rule
    function automatic bit exp_stall(input longint p, input longint rpm, input longint ppr);
        longint s = rpm * ((ppr == 0) ? 1 : ppr);
        return (s != 0) && ((p - 1) * s > longint'(K));
    endfunction

    task automatic cfg_ch(input int ch, input int ppr, input int rpm);
        wr(6'h10 + 6'(ch), 16'(ppr));
        wr(6'h20 + 6'(ch), 16'(rpm));
    endtask

    task automatic check_meas(input int ch, input int p, input int rpm, input int ppr, input string req);
        if (exp_stall(p, rpm, ppr)) begin
            chk(res_stall[ch] == 1'b1, req, res_stall[ch], 1);
            chk(cnt_of(ch) == '1, req, cnt_of(ch), 65535);
        end else begin
            chk(res_stall[ch] == 1'b0 && res_valid[ch] == 1'b1, req, {res_stall[ch], res_valid[ch]}, 1);
            chk(cnt_of(ch) == COUNT_W'(p - 1), req, cnt_of(ch), p - 1);
        end
    endtask

    initial begin
        int seed_init;
        logic [3:0] en_mask;
        seed_init = $urandom(1234);
        idle(3);
        rst_n = 1'b1;

        // R1: reset state
        chk(res_valid == '0 && res_stall == '0, "R1", {res_valid, res_stall}, 0);
        chk(res_count == '0, "R1", res_count, 0);

        // R1/R3: default divider 5 (tick every 1024) with default settings stalls on first tick
        wr(6'h01, 16'h0001);
        idle(940);
        chk(res_stall[0] == 1'b0, "R3 default divider, before first tick", res_stall[0], 0);
        idle(150);
        chk(res_stall[0] == 1'b1, "R1 default settings stall on first tick", res_stall[0], 1);

        // R7: disable clears the channel
        wr(6'h01, 16'h0000);
        idle(3);
        chk(res_valid[0] == 1'b0 && res_stall[0] == 1'b0 && cnt_of(0) == '0, "R7",
            {res_valid[0], res_stall[0]}, 0);

        // divider 0 for exact counts
        wr(6'h00, 16'h0000);
        cfg_ch(0, 2, 1000);
        wr(6'h01, 16'h0001);
        idle(2);
        chk(res_valid[0] == 1'b0, "R4 first edge only arms", res_valid[0], 0);
        burst3(0, 31);
        check_meas(0, 31, 1000, 2, "R5 interval at the limit is valid");
        idle(27);
        burst3(0, 32);
        check_meas(0, 32, 1000, 2, "R5 interval past the limit stalls");
        idle(28);
        burst3(0, 20);
        check_meas(0, 20, 1000, 2, "R6 recovery after stall");
        idle(16);

        // R2: level held high is one edge
        cfg_ch(1, 1, 0);
        wr(6'h01, 16'h0003);
        pulse(1); idle(18);
        tach_in[1] = 1'b1; idle(40); tach_in[1] = 1'b0; idle(10);
        pulse(1); idle(2);
        chk(cnt_of(1) == 16'd49, "R2 held level", cnt_of(1), 49);

        // R8: rpm 0 no stall, ppr 0 as 1
        burst3(1, 500);
        chk(cnt_of(1) == 16'd499 && !res_stall[1], "R8 rpm zero", cnt_of(1), 499);
        cfg_ch(1, 0, 1000);
        burst3(1, 61);
        check_meas(1, 61, 1000, 1, "R8 ppr zero acts as one, at limit");
        idle(57);
        burst3(1, 62);
        check_meas(1, 62, 1000, 1, "R8 ppr zero acts as one, past limit");

        // R3: prescaled ticks
        cfg_ch(1, 1, 0);
        wr(6'h00, 16'h0001);
        burst3(1, 40);
        chk(in_range(cnt_of(1), 40, 4), "R3 divider 1", cnt_of(1), 10);
        idle(36);
        wr(6'h00, 16'h0002);
        burst3(1, 160);
        chk(in_range(cnt_of(1), 160, 16), "R3 divider 2", cnt_of(1), 10);
        wr(6'h00, 16'h0000);
        idle(4);

        // R9: writes to unmapped addresses change nothing
        wr(6'h3F, 16'h0000);
        wr(6'h02, 16'h0000);
        wr(6'h10 + 6'(NUM_CH), 16'h000F);
        burst3(1, 30);
        chk(res_valid[1] && cnt_of(1) == 16'd29, "R9 unmapped writes ignored", cnt_of(1), 29);

        // R10: two channels at once
        cfg_ch(2, 1, 0);
        cfg_ch(0, 1, 0);
        wr(6'h01, 16'h0005);
        fork
            burst3(0, 17);
            burst3(2, 23);
        join
        chk(cnt_of(0) == 16'd16, "R10 channel 0", cnt_of(0), 16);
        chk(cnt_of(2) == 16'd22, "R10 channel 2", cnt_of(2), 22);
        chk(res_valid[3] == 1'b0, "R10 idle channel untouched", res_valid[3], 0);

        // random trials at divider 0
        en_mask = 4'h0;
        for (int t = 0; t < 24; t++) begin
            int ch  = int'($urandom_range(0, NUM_CH - 1));
            int ppr = int'($urandom_range(0, 15));
            int rpm = int'($urandom_range(0, 4000));
            int p   = int'($urandom_range(8, 120));
            wr(6'h01, 16'h0000);
            cfg_ch(ch, ppr, rpm);
            wr(6'h01, 16'(1 << ch));
            burst3(ch, p);
            check_meas(ch, p, rpm, ppr, "R4/R5 random trial");
            idle(p);
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule